// File: doc/BRIEF.md
# CPU Exception Acceptance Arbiter

This block sits beside a small CPU core and decides which pending exception the core takes. A reset request can arrive at any time. A trap is taken at any time while the program is running. Trace and interrupt requests are weighed only at an instruction or exception-handling boundary. That boundary is marked by a completion strobe. For an instruction, the strobe carries the class of the instruction that has just finished.

The winner appears for exactly one cycle on a one-hot output. With a reset, a flag also tells the core whether it is a power-on or a manual reset. The core then performs the handling sequence itself and reports its end on the handling-done strobe. The vector fetch, the stack frame, the interrupt controller's internal levels and the decoder all live elsewhere.

Top module: `exc_arbiter`

## Requirements
- R1: `acc_o` is one-hot or zero. Bit 0 means reset, bit 1 trace, bit 2 interrupt and bit 3 trap. It is zero in any cycle where nothing is accepted, and each acceptance lasts one cycle.
- R2: A reset is accepted in the cycle where `res_pin` is first seen high after being low. It is also accepted in any cycle with `res_pin` high and `wdt_ovf` asserted.
- R3: With an accepted reset, `rst_manual_o` equals the inverse of `nmi` in that cycle: 0 for power-on, 1 for manual. It is 0 in all other cycles.
- R4: While `res_pin` is low, nothing is accepted, whatever the other inputs do.
- R5: After a reset is accepted, no interrupt or trap is taken, and no trap is remembered, until `exc_done` arrives. That completion is a boundary where a trace may be taken but an interrupt is not.
- R6: Trace is accepted at a boundary (`insn_done` or `exc_done`) only when `trace_en` is 1 and `int_mode` is 2. In modes 0, 1 and 3 the trace bit has no effect.
- R7: No trace is taken when `insn_done` reports class 5 (return from exception).
- R8: An interrupt is accepted at a boundary while `irq` is high. It is not accepted when `insn_done` reports class 1, 2, 3 or 4 (the and/or/xor-to-control and load-control instructions). The request then stays pending and is taken at the next allowed boundary. Class 0 and class 5 do not block it.
- R9: When several requests meet in one cycle, only the highest is accepted, in the order reset, trace, interrupt, trap. An accepted reset discards a held trap.
- R10: A trap strobe in the running state is accepted in the same cycle unless something higher wins. If something higher wins, the trap is held and accepted in the first later cycle that has no higher acceptance.
- R11: Trace and interrupt are never accepted in a cycle without a completion strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low register reset |
| res_pin | input | 1 | External reset level; low holds the core in reset |
| wdt_ovf | input | 1 | Watchdog overflow strobe |
| nmi | input | 1 | Non-maskable interrupt pin level; selects the reset kind |
| trace_en | input | 1 | Trace bit from the status register |
| int_mode | input | 2 | Interrupt control mode |
| irq | input | 1 | Interrupt request level from the interrupt controller |
| trap_exec | input | 1 | Trap instruction execute strobe |
| insn_done | input | 1 | Instruction completion strobe |
| insn_class | input | 3 | Class of the completed instruction: 0 plain, 1 and-to-control, 2 or-to-control, 3 xor-to-control, 4 load-control, 5 return from exception |
| exc_done | input | 1 | Exception-handling completion strobe |
| acc_o | output | 4 | One-hot accepted exception |
| rst_manual_o | output | 1 | Reset kind with an accepted reset: 1 manual, 0 power-on |

## Verification
Several sources are made to collide in a single cycle. A trace and an interrupt land on the same boundary, together with a trap strobe. An interrupt and a trap coincide at a plain boundary. A watchdog strobe arrives together with every other request. Each collision is judged on two things: the one-hot winner in that cycle, and the next idle cycle. That idle cycle must show the held trap when something outranked it, and nothing when a reset wiped it.

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int          CLASS_W    = 3,
  parameter logic [1:0]  TRACE_MODE = 2'd2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               res_pin,
  input  logic               wdt_ovf,
  input  logic               nmi,
  input  logic               trace_en,
  input  logic [1:0]         int_mode,
  input  logic               irq,
  input  logic               trap_exec,
  input  logic               insn_done,
  input  logic [CLASS_W-1:0] insn_class,
  input  logic               exc_done,
  output logic [3:0]         acc_o,
  output logic               rst_manual_o
);

  localparam logic [CLASS_W-1:0] CL_ANDCTL = CLASS_W'(1);
  localparam logic [CLASS_W-1:0] CL_XORCTL = CLASS_W'(3);
  localparam logic [CLASS_W-1:0] CL_LDCTL  = CLASS_W'(4);
  localparam logic [CLASS_W-1:0] CL_RTE    = CLASS_W'(5);

  typedef enum logic [1:0] {S_HOLD, S_RSTWAIT, S_RUN} st_t;

  st_t  st;
  logic res_q, trap_pend;

  wire take_rst = res_pin & (~res_q | wdt_ovf);
  wire in_run   = res_pin & ~take_rst & (st == S_RUN);
  wire in_wait  = res_pin & ~take_rst & (st == S_RSTWAIT);
  wire bnd      = (in_run & (insn_done | exc_done)) | (in_wait & exc_done);
  wire is_rte   = insn_done & (insn_class == CL_RTE);
  wire is_ctl   = insn_done & (insn_class >= CL_ANDCTL) & (insn_class <= CL_LDCTL);

  wire want_trc = bnd & trace_en & (int_mode == TRACE_MODE) & ~is_rte;
  wire want_int = bnd & irq & ~is_ctl & ~in_wait;
  wire want_trp = in_run & (trap_exec | trap_pend);

  always_comb begin
    acc_o = 4'b0000;
    if (take_rst)      acc_o = 4'b0001;
    else if (want_trc) acc_o = 4'b0010;
    else if (want_int) acc_o = 4'b0100;
    else if (want_trp) acc_o = 4'b1000;
  end

  assign rst_manual_o = take_rst & ~nmi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_HOLD;
      res_q     <= 1'b0;
      trap_pend <= 1'b0;
    end else begin
      res_q <= res_pin;
      if (!res_pin) begin
        st        <= S_HOLD;
        trap_pend <= 1'b0;
      end else if (take_rst) begin
        st        <= S_RSTWAIT;
        trap_pend <= 1'b0;
      end else begin
        if (in_wait && exc_done) st <= S_RUN;
        trap_pend <= in_run & (trap_exec | trap_pend) & ~acc_o[3];
      end
    end
  end

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc_o));

  a_r3_kind: assert property (@(posedge clk) disable iff (!rst_n)
    rst_manual_o |-> (acc_o[0] && !nmi));

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !res_pin |-> (acc_o == 4'b0000));

  a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[0] |=> (!acc_o[2] && !acc_o[3]));

  a_r6_trace_gate: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[1] |-> (trace_en && int_mode == TRACE_MODE));

  a_r7_no_trace_rte: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[1] |-> !(insn_done && insn_class == CL_RTE));

  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    acc_o[2] |-> (irq && !(insn_done && insn_class >= CL_ANDCTL && insn_class <= CL_XORCTL)
                      && !(insn_done && insn_class == CL_LDCTL)));

  a_r11_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_o[1] || acc_o[2]) |-> (insn_done || exc_done));

endmodule

// File: tb/sim_exc_arbiter.sv
module sim_exc_arbiter;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       res_pin = 0, wdt_ovf = 0, nmi = 0, trace_en = 0, irq = 0;
  logic       trap_exec = 0, insn_done = 0, exc_done = 0;
  logic [1:0] int_mode = 2'd0;
  logic [2:0] insn_class = 3'd0;
  logic [3:0] acc_o;
  logic       rst_manual_o;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  exc_arbiter u0 (
    .clk(clk), .rst_n(rst_n), .res_pin(res_pin), .wdt_ovf(wdt_ovf), .nmi(nmi),
    .trace_en(trace_en), .int_mode(int_mode), .irq(irq), .trap_exec(trap_exec),
    .insn_done(insn_done), .insn_class(insn_class), .exc_done(exc_done),
    .acc_o(acc_o), .rst_manual_o(rst_manual_o)
  );

  task automatic step(input logic ins, input logic exd, input logic trp, input logic wdt,
                      input logic [2:0] cls, input logic [3:0] ea, input logic em,
                      input string req);
    insn_done = ins; exc_done = exd; trap_exec = trp; wdt_ovf = wdt; insn_class = cls;
    #1ns;
    checks++;
    if (acc_o !== ea || rst_manual_o !== em) begin
      failures++;
      $display("FAIL %s: acc=%b man=%b expected acc=%b man=%b", req, acc_o, rst_manual_o, ea, em);
    end
    @(negedge clk);
    insn_done = 0; exc_done = 0; trap_exec = 0; wdt_ovf = 0; insn_class = 3'd0;
  endtask

  task automatic t_hold();
    res_pin = 0; irq = 1; trace_en = 1; int_mode = 2'd2;
    step(1, 1, 1, 1, 3'd0, 4'b0000, 0, "R4");
    irq = 0; trace_en = 0; int_mode = 2'd0;
  endtask

  task automatic t_power_on();
    nmi = 1; res_pin = 1;
    step(0, 0, 0, 0, 3'd0, 4'b0001, 0, "R2");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R1");
    irq = 1;
    step(1, 0, 0, 0, 3'd0, 4'b0000, 0, "R5");
    step(0, 0, 1, 0, 3'd0, 4'b0000, 0, "R5");
    step(0, 1, 0, 0, 3'd0, 4'b0000, 0, "R5");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R5");
    step(1, 0, 0, 0, 3'd0, 4'b0100, 0, "R8");
    irq = 0;
  endtask

  task automatic t_manual();
    res_pin = 0;
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R4");
    nmi = 0; res_pin = 1;
    step(0, 0, 0, 0, 3'd0, 4'b0001, 1, "R3");
    trace_en = 1; int_mode = 2'd2; irq = 1;
    step(0, 1, 0, 0, 3'd0, 4'b0010, 0, "R5");
    trace_en = 0; irq = 0; nmi = 1;
  endtask

  task automatic t_watchdog();
    step(0, 0, 0, 1, 3'd0, 4'b0001, 0, "R2");
    step(0, 1, 0, 0, 3'd0, 4'b0000, 0, "R5");
    nmi = 0;
    step(0, 0, 0, 1, 3'd0, 4'b0001, 1, "R3");
    step(0, 1, 0, 0, 3'd0, 4'b0000, 0, "R5");
    nmi = 1;
  endtask

  task automatic t_trace();
    trace_en = 1; int_mode = 2'd2;
    step(1, 0, 0, 0, 3'd0, 4'b0010, 0, "R6");
    step(1, 0, 0, 0, 3'd5, 4'b0000, 0, "R7");
    int_mode = 2'd0;
    step(1, 0, 0, 0, 3'd0, 4'b0000, 0, "R6");
    int_mode = 2'd3;
    step(1, 0, 0, 0, 3'd0, 4'b0000, 0, "R6");
    int_mode = 2'd2; trace_en = 0;
    step(1, 0, 0, 0, 3'd0, 4'b0000, 0, "R6");
    trace_en = 1;
    step(0, 1, 0, 0, 3'd0, 4'b0010, 0, "R6");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R11");
    trace_en = 0;
  endtask

  task automatic t_irq();
    irq = 1;
    for (int c = 1; c <= 4; c++) step(1, 0, 0, 0, 3'(c), 4'b0000, 0, "R8");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R11");
    step(1, 0, 0, 0, 3'd0, 4'b0100, 0, "R8");
    step(1, 0, 0, 0, 3'd5, 4'b0100, 0, "R8");
    irq = 0;
  endtask

  task automatic t_priority();
    trace_en = 1; int_mode = 2'd2; irq = 1;
    step(1, 0, 1, 0, 3'd0, 4'b0010, 0, "R9");
    trace_en = 0;
    step(0, 0, 0, 0, 3'd0, 4'b1000, 0, "R10");
    step(1, 0, 1, 0, 3'd0, 4'b0100, 0, "R9");
    step(0, 0, 0, 0, 3'd0, 4'b1000, 0, "R10");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R10");
    trace_en = 1;
    step(1, 0, 1, 1, 3'd0, 4'b0001, 0, "R9");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R9");
    step(0, 1, 0, 0, 3'd0, 4'b0010, 0, "R5");
    trace_en = 0; irq = 0;
  endtask

  task automatic t_trap();
    step(0, 0, 1, 0, 3'd0, 4'b1000, 0, "R10");
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R10");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    step(0, 0, 0, 0, 3'd0, 4'b0000, 0, "R4");
    t_hold();
    t_power_on();
    t_manual();
    t_watchdog();
    t_trace();
    t_irq();
    t_priority();
    t_trap();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: acc=%b man=%b expected completion", acc_o, rst_manual_o);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule